// File: doc/BRIEF.md
# 68000 Board-Pin Bus Adapter

This block sits between a simplified soft core with a 68000-style instruction set and the pins of a motherboard socket built for the real processor. The core uses active-high internal controls and has no function-code, reset-out or output-enable pins. The adapter turns those controls into the board's active-low strobes and the read/write level. It derives the three function-code bits from the core's supervisor, fetch and interrupt-acknowledge status. It also produces output enables, so that pad logic outside the block can tri-state the address, data, strobe and function-code pins.

The board reset line is open-drain with a pull-up. The block therefore never drives it high. It signals "drive low" through an enable only while the core requests a reset after a software RESET instruction. The line is read back, inverted, and turned into the core's active-high reset. That reset asserts asynchronously and releases through a chain of two flip-flops. The block's own pull-down is masked out, so a reset request from the core never resets the core itself. The incoming acknowledge (active low) reaches the core inverted, and the interrupt level reaches it unchanged. Both pass through two synchronizing flip-flops first. All bus-side outputs are registered and update one rising edge after the core presents them.

Top module: `m68k_pin_glue`

## Requirements
- R1: While the board reset pin reads 0 and the block has not driven it in the current or previous cycle, `core_reset` is 1 at once, without waiting for a clock edge.
- R2: When the board reset pin returns to 1, `core_reset` stays 1 after the first rising edge and falls to 0 after the second.
- R3: `reset_pin_oe` (1 = pull the board reset pin to 0) is 1 after each rising edge at which `core_reset_req` was 1 and `core_reset` was 0, and 0 otherwise.
- R4: The block pulling the reset pin low, including the cycle in which it releases it, never asserts `core_reset`.
- R5: `core_dtack` (active high) equals the inverse of `dtack_n` as sampled two rising edges earlier, and is 0 while `core_reset` is 1.
- R6: `core_ipl_n` equals `ipl_n` as sampled two rising edges earlier, without inversion, and is 3'b111 while `core_reset` is 1.
- R7: One edge after the core inputs are sampled, `fc_pin` is 3'b111 when `core_intack` is 1. Otherwise it is {`core_super`, `core_fetch`, not `core_fetch`}, which gives user data 001, user program 010, supervisor data 101 and supervisor program 110.
- R8: One edge after sampling, `as_n`, `uds_n` and `lds_n` are the inverses of `core_as`, `core_uds` and `core_lds`. `rw_n` equals `core_rw` (1 = read), `addr_pin` equals `core_addr`, and `bus_oe` is 1 whenever `core_reset` was 0 at that edge.
- R9: One edge after sampling, `data_oe` equals `core_drive_data` and `data_pin` equals `core_wdata`.
- R10: After any rising edge at which `core_reset` is 1, `bus_oe`, `data_oe` and `reset_pin_oe` are 0 and `as_n`, `uds_n`, `lds_n` and `rw_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Adapter clock, shared with the core |
| rst_pin_n | input | 1 | Level read back from the open-drain board reset line |
| dtack_n | input | 1 | Board acknowledge, active low |
| ipl_n | input | 3 | Board interrupt level, active low |
| core_reset_req | input | 1 | Core asks to reset the board (RESET instruction) |
| core_as | input | 1 | Core address strobe, active high |
| core_uds | input | 1 | Core upper byte strobe, active high |
| core_lds | input | 1 | Core lower byte strobe, active high |
| core_rw | input | 1 | Core direction, 1 = read |
| core_addr | input | ADDR_W | Core word address |
| core_wdata | input | DATA_W | Core write data |
| core_drive_data | input | 1 | Core wants the data pins driven |
| core_super | input | 1 | Core is in supervisor state |
| core_fetch | input | 1 | Current cycle fetches program words |
| core_intack | input | 1 | Current cycle is an interrupt acknowledge |
| core_reset | output | 1 | Active-high reset into the core |
| core_dtack | output | 1 | Active-high acknowledge into the core |
| core_ipl_n | output | 3 | Synchronized interrupt level into the core |
| reset_pin_oe | output | 1 | 1 = pull board reset pin to 0, 0 = release |
| addr_pin | output | ADDR_W | Address pin values |
| data_pin | output | DATA_W | Data pin values |
| data_oe | output | 1 | Enable for the data pins |
| as_n | output | 1 | Address strobe pin, active low |
| uds_n | output | 1 | Upper data strobe pin, active low |
| lds_n | output | 1 | Lower data strobe pin, active low |
| rw_n | output | 1 | Read/write pin, 1 = read |
| fc_pin | output | 3 | Function-code pins |
| bus_oe | output | 1 | Enable for address, strobe, R/W and function-code pins |

## Verification
A wrong synchronizer or reset-bridge state shows up as `core_reset` or `core_dtack` moving one edge early or late against the fixed two-edge window. It also shows as the core resetting itself while `reset_pin_oe` is high, which would be visible within one or two cycles of a request. A stuck or wrong output register shows on the very next edge as a mismatched strobe, function code or enable. Interrupt-acknowledge cycles are compared against 3'b111, and reset windows are compared against fully released pins.

// File: rtl/m68kg_pkg.sv
package m68kg_pkg;

  typedef logic [2:0] fc_t;

  localparam fc_t FC_CPU_SPACE = 3'b111;

  // Normal cycles: bit2 = supervisor, bit1 = program fetch, bit0 = data access.
  function automatic fc_t fc_encode(input logic super_st, input logic fetch, input logic intack);
    fc_t f;
    if (intack) f = FC_CPU_SPACE;
    else        f = {super_st, fetch, ~fetch};
    return f;
  endfunction

endpackage

// File: rtl/m68kg_sync.sv
module m68kg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else     stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/m68kg_rst_bridge.sv
module m68kg_rst_bridge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic core_reset_req,
  output logic core_rst,
  output logic pin_drive
);

  logic             drive_q;
  logic             drive_hold;
  logic             ext_low;
  logic [STAGES-1:0] rst_chain;

  // Own pull-down is masked for the drive cycle and one more, covering the release edge.
  assign ext_low = ~rst_pin_n & ~(drive_q | drive_hold);

  always_ff @(posedge clk or posedge ext_low) begin
    if (ext_low) rst_chain <= '1;
    else         rst_chain <= {rst_chain[STAGES-2:0], 1'b0};
  end

  assign core_rst = rst_chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (core_rst) begin
      drive_q    <= 1'b0;
      drive_hold <= 1'b0;
    end else begin
      drive_q    <= core_reset_req;
      drive_hold <= drive_q;
    end
  end

  assign pin_drive = drive_q;

  AST_PIN_DRIVE_ON_REQ: assert property (@(posedge clk) disable iff (core_rst)
    drive_q |-> $past(core_reset_req)); // R3

  AST_NO_SELF_RESET: assert property (@(posedge clk) disable iff (core_rst)
    drive_q |=> !core_rst); // R4

endmodule

// File: rtl/m68kg_bus_drive.sv
module m68kg_bus_drive
  import m68kg_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              core_rst,
  input  logic              core_as,
  input  logic              core_uds,
  input  logic              core_lds,
  input  logic              core_rw,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_drive_data,
  input  logic              core_super,
  input  logic              core_fetch,
  input  logic              core_intack,
  output logic [ADDR_W-1:0] addr_pin,
  output logic [DATA_W-1:0] data_pin,
  output logic              data_oe,
  output logic              as_n,
  output logic              uds_n,
  output logic              lds_n,
  output logic              rw_n,
  output fc_t               fc_pin,
  output logic              bus_oe
);

  always_ff @(posedge clk) begin
    if (core_rst) begin
      addr_pin <= '0;
      data_pin <= '0;
      data_oe  <= 1'b0;
      as_n     <= 1'b1;
      uds_n    <= 1'b1;
      lds_n    <= 1'b1;
      rw_n     <= 1'b1;
      fc_pin   <= '0;
      bus_oe   <= 1'b0;
    end else begin
      addr_pin <= core_addr;
      data_pin <= core_wdata;
      data_oe  <= core_drive_data;
      as_n     <= ~core_as;
      uds_n    <= ~core_uds;
      lds_n    <= ~core_lds;
      rw_n     <= core_rw;
      fc_pin   <= fc_encode(core_super, core_fetch, core_intack);
      bus_oe   <= 1'b1;
    end
  end

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    core_rst |=> (!bus_oe && !data_oe && as_n && uds_n && lds_n && rw_n)); // R10

  AST_INTACK_CPU_SPACE: assert property (@(posedge clk) disable iff (core_rst)
    core_intack |=> (fc_pin == FC_CPU_SPACE)); // R7

  AST_DATA_OE_FOLLOWS: assert property (@(posedge clk) disable iff (core_rst)
    data_oe |-> $past(core_drive_data)); // R9

endmodule

// File: rtl/m68k_pin_glue.sv
module m68k_pin_glue
  import m68kg_pkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              dtack_n,
  input  logic [2:0]        ipl_n,
  input  logic              core_reset_req,
  input  logic              core_as,
  input  logic              core_uds,
  input  logic              core_lds,
  input  logic              core_rw,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_drive_data,
  input  logic              core_super,
  input  logic              core_fetch,
  input  logic              core_intack,
  output logic              core_reset,
  output logic              core_dtack,
  output logic [2:0]        core_ipl_n,
  output logic              reset_pin_oe,
  output logic [ADDR_W-1:0] addr_pin,
  output logic [DATA_W-1:0] data_pin,
  output logic              data_oe,
  output logic              as_n,
  output logic              uds_n,
  output logic              lds_n,
  output logic              rw_n,
  output logic [2:0]        fc_pin,
  output logic              bus_oe
);

  localparam int IPL_W = 3;

  logic rst_int;
  logic dtack_n_s;

  m68kg_rst_bridge #(.STAGES(SYNC_STAGES)) u_rst (
    .clk            (clk),
    .rst_pin_n      (rst_pin_n),
    .core_reset_req (core_reset_req),
    .core_rst       (rst_int),
    .pin_drive      (reset_pin_oe)
  );

  m68kg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dtack_sync (
    .clk (clk),
    .rst (rst_int),
    .d   (dtack_n),
    .q   (dtack_n_s)
  );

  m68kg_sync #(.W(IPL_W), .STAGES(SYNC_STAGES), .RST_VAL({IPL_W{1'b1}})) u_ipl_sync (
    .clk (clk),
    .rst (rst_int),
    .d   (ipl_n),
    .q   (core_ipl_n)
  );

  assign core_dtack = ~dtack_n_s;
  assign core_reset = rst_int;

  m68kg_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk             (clk),
    .core_rst        (rst_int),
    .core_as         (core_as),
    .core_uds        (core_uds),
    .core_lds        (core_lds),
    .core_rw         (core_rw),
    .core_addr       (core_addr),
    .core_wdata      (core_wdata),
    .core_drive_data (core_drive_data),
    .core_super      (core_super),
    .core_fetch      (core_fetch),
    .core_intack     (core_intack),
    .addr_pin        (addr_pin),
    .data_pin        (data_pin),
    .data_oe         (data_oe),
    .as_n            (as_n),
    .uds_n           (uds_n),
    .lds_n           (lds_n),
    .rw_n            (rw_n),
    .fc_pin          (fc_pin),
    .bus_oe          (bus_oe)
  );

  AST_RESET_RELEASES_PIN: assert property (@(posedge clk)
    rst_int |=> !reset_pin_oe); // R10

  AST_DTACK_IDLE_IN_RESET: assert property (@(posedge clk)
    rst_int |=> !core_dtack || !rst_int); // R5

endmodule

// File: tb/sim_m68k_pin_glue.sv
module sim_m68k_pin_glue;
  localparam int CLK_NS = 10;
  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic ext_low;
  logic rst_pin_n, dtack_n, core_reset_req, core_as, core_uds, core_lds, core_rw;
  logic [2:0] ipl_n;
  logic [AW-1:0] core_addr;
  logic [DW-1:0] core_wdata;
  logic core_drive_data, core_super, core_fetch, core_intack;
  logic core_reset, core_dtack, reset_pin_oe, data_oe, as_n, uds_n, lds_n, rw_n, bus_oe;
  logic [2:0] core_ipl_n, fc_pin;
  logic [AW-1:0] addr_pin;
  logic [DW-1:0] data_pin;

  // Open-drain line with pull-up: low if the board or the adapter pulls it.
  assign rst_pin_n = !(ext_low || reset_pin_oe);

  m68k_pin_glue u0 (
    .clk(clk), .rst_pin_n(rst_pin_n), .dtack_n(dtack_n), .ipl_n(ipl_n),
    .core_reset_req(core_reset_req), .core_as(core_as), .core_uds(core_uds),
    .core_lds(core_lds), .core_rw(core_rw), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_drive_data(core_drive_data),
    .core_super(core_super), .core_fetch(core_fetch), .core_intack(core_intack),
    .core_reset(core_reset), .core_dtack(core_dtack), .core_ipl_n(core_ipl_n),
    .reset_pin_oe(reset_pin_oe), .addr_pin(addr_pin), .data_pin(data_pin),
    .data_oe(data_oe), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .rw_n(rw_n),
    .fc_pin(fc_pin), .bus_oe(bus_oe)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] fc_model(input logic s, input logic f, input logic ia);
    if (ia) return 3'b111;
    if (s && f)  return 3'b110;
    if (s)       return 3'b101;
    if (f)       return 3'b010;
    return 3'b001;
  endfunction

  task automatic edge_sample;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_NS*200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic prev_dn;
    logic [2:0] prev_ipl;
    logic cur_dn;
    logic [2:0] cur_ipl;
    logic e_as, e_uds, e_lds, e_rw, e_dd, e_s, e_f, e_ia, e_req;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_wd;

    void'($urandom(32'd5150));
    ext_low = 0; dtack_n = 1; ipl_n = 3'b111;
    core_reset_req = 0; core_as = 0; core_uds = 0; core_lds = 0; core_rw = 1;
    core_addr = '0; core_wdata = '0; core_drive_data = 0;
    core_super = 0; core_fetch = 0; core_intack = 0;

    #1 ext_low = 1;
    #1 chk("R1 async assert", core_reset, 1);

    // Activity requested during reset must stay off the pins.
    core_reset_req = 1; core_drive_data = 1; core_as = 1;
    repeat (3) edge_sample();
    chk("R10 bus_oe in reset", bus_oe, 0);
    chk("R10 data_oe in reset", data_oe, 0);
    chk("R10 as_n in reset", as_n, 1);
    chk("R10 reset_pin_oe in reset", reset_pin_oe, 0);
    chk("R5 dtack idle in reset", core_dtack, 0);
    chk("R6 ipl idle in reset", core_ipl_n, 3'b111);
    core_reset_req = 0; core_drive_data = 0; core_as = 0;

    @(negedge clk) ext_low = 0;
    edge_sample(); chk("R2 still held after edge 1", core_reset, 1);
    edge_sample(); chk("R2 released after edge 2", core_reset, 0);
    chk("R10 bus_oe off at release edge", bus_oe, 0);
    edge_sample(); chk("R8 bus_oe on", bus_oe, 1);

    // Core-issued reset request.
    @(negedge clk) core_reset_req = 1;
    edge_sample();
    chk("R3 pin pulled on request", reset_pin_oe, 1);
    chk("R4 no self reset", core_reset, 0);
    for (int i = 0; i < 3; i++) begin
      edge_sample(); chk("R4 no self reset while driving", core_reset, 0);
    end
    @(negedge clk) core_reset_req = 0;
    edge_sample(); chk("R3 pin released", reset_pin_oe, 0);
    for (int i = 0; i < 3; i++) begin
      edge_sample(); chk("R4 no reset on release", core_reset, 0);
    end

    // Acknowledge and interrupt level latency.
    @(negedge clk) begin dtack_n = 0; ipl_n = 3'b010; end
    edge_sample();
    chk("R5 dtack after one edge", core_dtack, 0);
    chk("R6 ipl after one edge", core_ipl_n, 3'b111);
    edge_sample();
    chk("R5 dtack after two edges", core_dtack, 1);
    chk("R6 ipl after two edges", core_ipl_n, 3'b010);

    cur_dn = dtack_n; cur_ipl = ipl_n;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      prev_dn = cur_dn; prev_ipl = cur_ipl;
      cur_dn = 1'($urandom); cur_ipl = 3'($urandom);
      e_as = 1'($urandom); e_uds = 1'($urandom); e_lds = 1'($urandom);
      e_rw = 1'($urandom); e_dd = 1'($urandom); e_s = 1'($urandom);
      e_f = 1'($urandom); e_ia = (($urandom % 4) == 0); e_req = (($urandom % 8) == 0);
      e_addr = AW'($urandom); e_wd = DW'($urandom);
      if (n == 0)   begin e_ia = 1; e_s = 0; e_f = 0; end
      if (n == 1)   begin e_ia = 0; e_s = 1; e_f = 1; end
      dtack_n = cur_dn; ipl_n = cur_ipl;
      core_as = e_as; core_uds = e_uds; core_lds = e_lds; core_rw = e_rw;
      core_drive_data = e_dd; core_super = e_s; core_fetch = e_f; core_intack = e_ia;
      core_reset_req = e_req; core_addr = e_addr; core_wdata = e_wd;
      edge_sample();
      chk("R5 dtack", core_dtack, !prev_dn);
      chk("R6 ipl", core_ipl_n, prev_ipl);
      chk("R7 fc", fc_pin, fc_model(e_s, e_f, e_ia));
      chk("R8 strobes", {as_n, uds_n, lds_n, rw_n}, {!e_as, !e_uds, !e_lds, e_rw});
      chk("R8 addr", addr_pin, e_addr);
      chk("R8 bus_oe", bus_oe, 1);
      chk("R9 data", {data_oe, data_pin}, {e_dd, e_wd});
      chk("R3 reset drive", reset_pin_oe, e_req);
      chk("R4 core reset", core_reset, 0);
    end

    // Board reset arrives mid-traffic.
    @(negedge clk) begin
      core_reset_req = 0; core_as = 1; core_drive_data = 1;
    end
    edge_sample();
    #2 ext_low = 1;
    #1 chk("R1 async assert mid-run", core_reset, 1);
    edge_sample();
    chk("R10 bus_oe dropped", bus_oe, 0);
    chk("R10 data_oe dropped", data_oe, 0);
    chk("R10 strobes released", {as_n, uds_n, lds_n, rw_n}, 4'hF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule